// File: doc/BRIEF.md
# EPP Cycle Gate with Transfer Timeout

This block is the enhanced-parallel-port half of a host-side parallel interface. A host bus issues byte-addressed register accesses. Accesses to the EPP address port and the EPP data port become transfer requests on a byte-wide request/acknowledge link, but only while the control register holds the one bit pattern that enables that direction. Accesses that are not enabled complete at once and never reach the link.

Data-port accesses can be 8, 16 or 32 bits wide. A wide access is moved as one transfer made of 2 or 4 link bytes, least significant byte first. Each link byte must be acknowledged within a parameterised number of clock cycles. If it is not, the transfer is abandoned and a sticky timeout flag is set. Software reads that flag in status bit 0 and clears it by writing a 1 there.

The bus access stalls until the block pulses its ready output. A control write that flips the direction bit pulses a direction-change strobe toward the link. A second address region, selected by the top address bit, behaves as an empty register window.

Top module: `epp_cycle_gate`

## Requirements
- R1: After reset, the control register reads 0xCC, status bit 0 (timeout) reads 0, busReady is low and linkReq is low.
- R2: Only busAddr[2:0] selects a register when busAddr[10] is 0. Offset 1 is status, offset 2 is control, offset 3 is the EPP address port (linkIsAddr=1) and offset 4 is the EPP data port (linkIsAddr=0). Reads at any other offset return all ones within the access width.
- R3: An EPP write proceeds only if control AND 0x2F equals 0x04. Bit 5 is direction, bit 3 select, bit 2 init, bit 1 auto-feed, bit 0 strobe. Otherwise the write completes with no link request.
- R4: An EPP read proceeds only if control AND 0x2F equals 0x24. Otherwise it completes with no link request and returns all ones within the access width.
- R5: busSize 0, 1 and 2 select 8, 16 and 32 bits; busSize 3 acts as 8 bits. A data-port access moves 1, 2 or 4 link bytes, least significant first, with linkWrite giving the direction. Read bytes are assembled little-endian. busRdata bits above the access width read 0.
- R6: When a link byte gets no acknowledge within TIMEOUT_CYCLES cycles of linkReq, the transfer stops, no further bytes are requested and the timeout flag is set. A read that times out returns all ones within the width. An acknowledge in the last allowed cycle counts as success.
- R7: The timeout flag is sticky and reads in status bit 0; bits 7:1 mirror lineStatus. A status write with bit 0 set clears the flag. A status write with bit 0 clear leaves it unchanged.
- R8: A control write stores the written byte with bits 7:6 forced to 1. linkDir follows control bit 5. linkDirPulse is high for one cycle after a control write that changes bit 5, and never otherwise.
- R9: With busAddr[10] set, reads return all ones within the access width and writes change no register and request nothing on the link.
- R10: busReady is a single-cycle pulse ending each access. During a transfer, linkReq stays high until linkAck or timeout, and linkWdata stays stable while linkReq is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | 1 | Access request, held until busReady |
| busWrite | input | 1 | 1 = write access |
| busAddr | input | 11 | Byte address; bit 10 selects the empty region |
| busSize | input | 2 | Access width code |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid with busReady |
| busReady | output | 1 | Access completion pulse |
| lineStatus | input | 7 | Port status lines shown in status bits 7:1 |
| linkReq | output | 1 | Link byte request |
| linkIsAddr | output | 1 | Request is an address cycle |
| linkWrite | output | 1 | Request is a host-to-link byte |
| linkWdata | output | 8 | Byte sent to the link |
| linkAck | input | 1 | Link acknowledge for the current byte |
| linkRdata | input | 8 | Byte returned by the link, valid with linkAck |
| linkDir | output | 1 | Current port direction (1 = link to host) |
| linkDirPulse | output | 1 | One-cycle direction change strobe |

## Verification
The acknowledge for a link byte and the expiry of that byte's timeout window can fall on the same clock edge. The bench provokes this by setting its responder's acknowledge delay to exactly TIMEOUT_CYCLES-1 cycles, and then to one cycle more. In the first case the transfer must complete, with the byte logged and the flag still clear. In the second the flag must be set, no byte may be logged and a read must return all ones. Random control patterns, widths and directions are mixed with directed cases, and each result is compared with values the bench computes from the gate patterns and the byte log.

// File: rtl/epp_pkg.sv
package epp_pkg;

  // control register bit positions (software-visible, so positions matter)
  localparam int CTL_DIR  = 5;
  localparam int CTL_SEL  = 3;
  localparam int CTL_INIT = 2;
  localparam int CTL_AFD  = 1;
  localparam int CTL_STB  = 0;

  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;
  localparam logic [7:0] CTL_FORCED = 8'hC0;
  localparam logic [7:0] CTL_RESET  = 8'hCC;

  localparam logic [2:0] OFS_STS   = 3'd1;
  localparam logic [2:0] OFS_CTL   = 3'd2;
  localparam logic [2:0] OFS_EADDR = 3'd3;
  localparam logic [2:0] OFS_EDATA = 3'd4;

  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = BUS_BYTES * 8;
  localparam int IDX_W     = $clog2(BUS_BYTES);

  typedef enum logic [1:0] {
    SZ_B8  = 2'd0,
    SZ_B16 = 2'd1,
    SZ_B32 = 2'd2,
    SZ_RSV = 2'd3
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             accept;
    logic             ctlWr;
    logic             stsClr;
    logic             capByte;
    logic             setTmo;
    logic             fillOnes;
    logic [IDX_W-1:0] idx;
  } dpStrobe_t;

  function automatic logic [BUS_W-1:0] sizeMask(input logic [1:0] sz);
    case (sz)
      SZ_B16:  sizeMask = 32'h0000_FFFF;
      SZ_B32:  sizeMask = 32'hFFFF_FFFF;
      default: sizeMask = 32'h0000_00FF;
    endcase
  endfunction

  function automatic logic [IDX_W-1:0] lastByte(input logic isAddr, input logic [1:0] sz);
    if (isAddr) lastByte = '0;
    else begin
      case (sz)
        SZ_B16:  lastByte = IDX_W'(1);
        SZ_B32:  lastByte = IDX_W'(BUS_BYTES - 1);
        default: lastByte = '0;
      endcase
    end
  endfunction

endpackage

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16,
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busReq,
  input  logic       busWrite,
  input  logic [2:0] busOfs,
  input  logic       busExt,
  input  logic [1:0] busSize,
  input  logic       busWdataB0,
  input  logic [7:0] ctrlReg,
  input  logic       linkAck,
  output dpStrobe_t  stb,
  output logic       busReady,
  output logic       linkReq,
  output logic       linkIsAddr,
  output logic       linkWrite
);

  localparam logic [TMR_W-1:0] TMO_LAST = TMR_W'(TIMEOUT_CYCLES - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_GAP, ST_DONE} state_e;

  state_e           state, nState;
  logic [TMR_W-1:0] timer;
  logic [IDX_W-1:0] idx, lastIdx;
  logic             isAddrQ, writeQ;

  logic isEpp, gateOk, regWrite, portIsAddr;

  always_comb begin
    portIsAddr = (busOfs == OFS_EADDR);
    isEpp      = !busExt && (portIsAddr || busOfs == OFS_EDATA);
    gateOk     = busWrite ? ((ctrlReg & GATE_MASK) == GATE_WR)
                          : ((ctrlReg & GATE_MASK) == GATE_RD);
    regWrite   = busWrite && !busExt;
  end

  always_comb begin
    stb      = '0;
    stb.idx  = idx;
    busReady = 1'b0;
    linkReq  = 1'b0;
    nState   = state;
    case (state)
      ST_IDLE: begin
        if (busReq) begin
          stb.accept = 1'b1;
          stb.ctlWr  = regWrite && (busOfs == OFS_CTL);
          stb.stsClr = regWrite && (busOfs == OFS_STS) && busWdataB0;
          nState     = (isEpp && gateOk) ? ST_XFER : ST_DONE;
        end
      end
      ST_XFER: begin
        linkReq = 1'b1;
        if (linkAck) begin
          stb.capByte = !writeQ;
          nState      = (idx == lastIdx) ? ST_DONE : ST_GAP;
        end else if (timer == TMO_LAST) begin
          stb.setTmo   = 1'b1;
          stb.fillOnes = !writeQ;
          nState       = ST_DONE;
        end
      end
      ST_GAP:  nState = ST_XFER;
      ST_DONE: begin
        busReady = 1'b1;
        nState   = ST_IDLE;
      end
      default: nState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      timer   <= '0;
      idx     <= '0;
      lastIdx <= '0;
      isAddrQ <= 1'b0;
      writeQ  <= 1'b0;
    end else begin
      state <= nState;
      case (state)
        ST_IDLE: begin
          timer <= '0;
          if (busReq) begin
            idx     <= '0;
            isAddrQ <= portIsAddr;
            writeQ  <= busWrite;
            lastIdx <= lastByte(portIsAddr, busSize);
          end
        end
        ST_XFER: begin
          if (linkAck) begin
            timer <= '0;
            idx   <= idx + IDX_W'(1);
          end else begin
            timer <= timer + TMR_W'(1);
          end
        end
        default: timer <= '0;
      endcase
    end
  end

  assign linkIsAddr = isAddrQ;
  assign linkWrite  = writeQ;

  // R3: a host-to-link request only exists under the write pattern
  a_r3_write_gate : assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && linkWrite) |-> ((ctrlReg & GATE_MASK) == GATE_WR));

  // R4: a link-to-host request only exists under the read pattern
  a_r4_read_gate : assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && !linkWrite) |-> ((ctrlReg & GATE_MASK) == GATE_RD));

  // R6: the wait counter never runs past the allowed window
  a_r6_window : assert property (@(posedge clk) disable iff (!rstN)
    linkReq |-> (timer <= TMO_LAST));

  // R9: an access to the empty region never reaches the link
  a_r9_ext_quiet : assert property (@(posedge clk) disable iff (!rstN)
    (stb.accept && busExt) |=> !linkReq);

  // R10: ready is a single-cycle pulse
  a_r10_ready_pulse : assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R10: request held until acknowledge or expiry
  a_r10_req_hold : assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && !linkAck && timer != TMO_LAST) |=> linkReq);

endmodule

// File: rtl/epp_dp.sv
module epp_dp
  import epp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        stb,
  input  logic [2:0]       busOfs,
  input  logic             busExt,
  input  logic [1:0]       busSize,
  input  logic [BUS_W-1:0] busWdata,
  input  logic [6:0]       lineStatus,
  input  logic [7:0]       linkRdata,
  output logic [7:0]       ctrlReg,
  output logic [BUS_W-1:0] busRdata,
  output logic [7:0]       linkWdata,
  output logic             linkDirPulse
);

  logic             tmoFlag;
  logic [BUS_W-1:0] wrBuf, rdBuf;
  logic [1:0]       sizeQ;
  logic [7:0]       regVal;

  always_comb begin
    regVal = 8'hFF;
    if (!busExt) begin
      case (busOfs)
        OFS_STS: regVal = {lineStatus, tmoFlag};
        OFS_CTL: regVal = ctrlReg;
        default: regVal = 8'hFF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg      <= CTL_RESET;
      tmoFlag      <= 1'b0;
      wrBuf        <= '0;
      rdBuf        <= '1;
      sizeQ        <= SZ_B8;
      linkDirPulse <= 1'b0;
    end else begin
      linkDirPulse <= 1'b0;
      if (stb.accept) begin
        wrBuf <= busWdata;
        sizeQ <= busSize;
        rdBuf <= {{(BUS_W-8){1'b1}}, regVal};
      end
      if (stb.ctlWr) begin
        ctrlReg      <= busWdata[7:0] | CTL_FORCED;
        linkDirPulse <= busWdata[CTL_DIR] != ctrlReg[CTL_DIR];
      end
      if (stb.stsClr) tmoFlag <= 1'b0;
      if (stb.setTmo) tmoFlag <= 1'b1;
      if (stb.capByte) rdBuf[stb.idx*8 +: 8] <= linkRdata;
      if (stb.fillOnes) rdBuf <= '1;
    end
  end

  assign busRdata  = rdBuf & sizeMask(sizeQ);
  assign linkWdata = wrBuf[stb.idx*8 +: 8];

  // R6: the flag only rises on a recorded expiry
  a_r6_flag_source : assert property (@(posedge clk) disable iff (!rstN)
    $rose(tmoFlag) |-> $past(stb.setTmo));

  // R7: the flag only falls on a clearing status write
  a_r7_sticky : assert property (@(posedge clk) disable iff (!rstN)
    $fell(tmoFlag) |-> $past(stb.stsClr));

  // R8: the direction strobe marks a real change of the direction bit
  a_r8_dir_pulse : assert property (@(posedge clk) disable iff (!rstN)
    linkDirPulse |-> (ctrlReg[CTL_DIR] != $past(ctrlReg[CTL_DIR])));

  // R8: forced bits always read as ones
  a_r8_forced : assert property (@(posedge clk) disable iff (!rstN)
    ctrlReg[7:6] == 2'b11);

endmodule

// File: rtl/epp_cycle_gate.sv
module epp_cycle_gate
  import epp_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 16,
  parameter int ADDR_W         = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busReq,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [1:0]        busSize,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              busReady,
  input  logic [6:0]        lineStatus,
  output logic              linkReq,
  output logic              linkIsAddr,
  output logic              linkWrite,
  output logic [7:0]        linkWdata,
  input  logic              linkAck,
  input  logic [7:0]        linkRdata,
  output logic              linkDir,
  output logic              linkDirPulse
);

  dpStrobe_t  stb;
  logic [7:0] ctrlReg;
  logic       busExt;
  logic [2:0] busOfs;

  assign busExt  = busAddr[ADDR_W-1];
  assign busOfs  = busAddr[2:0];
  assign linkDir = ctrlReg[CTL_DIR];

  epp_ctrl #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busReq     (busReq),
    .busWrite   (busWrite),
    .busOfs     (busOfs),
    .busExt     (busExt),
    .busSize    (busSize),
    .busWdataB0 (busWdata[0]),
    .ctrlReg    (ctrlReg),
    .linkAck    (linkAck),
    .stb        (stb),
    .busReady   (busReady),
    .linkReq    (linkReq),
    .linkIsAddr (linkIsAddr),
    .linkWrite  (linkWrite)
  );

  epp_dp uDp (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .busOfs       (busOfs),
    .busExt       (busExt),
    .busSize      (busSize),
    .busWdata     (busWdata),
    .lineStatus   (lineStatus),
    .linkRdata    (linkRdata),
    .ctrlReg      (ctrlReg),
    .busRdata     (busRdata),
    .linkWdata    (linkWdata),
    .linkDirPulse (linkDirPulse)
  );

  // R10: the outgoing byte holds while a request waits
  a_r10_wdata_stable : assert property (@(posedge clk) disable iff (!rstN)
    (linkReq && !linkAck) |=> (!linkReq || $stable(linkWdata)));

endmodule

// File: tb/tb_epp_cycle_gate.sv
module tb_epp_cycle_gate;

  localparam int TMO = 6;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busReq = 1'b0, busWrite = 1'b0;
  logic [10:0] busAddr = '0;
  logic [1:0]  busSize = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady;
  logic [6:0]  lineStatus = 7'h55;
  logic        linkReq, linkIsAddr, linkWrite, linkDir, linkDirPulse;
  logic [7:0]  linkWdata;
  logic        linkAck = 1'b0;
  logic [7:0]  linkRdata = '0;

  int checks = 0, fails = 0;
  int ackDelay = 0, waitCnt = 0;
  int logCount = 0, pulses = 0;
  logic [7:0] logData [0:1023];
  logic       logAddr [0:1023];
  logic       logWr   [0:1023];

  always #2 clk = ~clk;

  epp_cycle_gate #(.TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rstN(rstN), .busReq(busReq), .busWrite(busWrite),
    .busAddr(busAddr), .busSize(busSize), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .lineStatus(lineStatus),
    .linkReq(linkReq), .linkIsAddr(linkIsAddr), .linkWrite(linkWrite),
    .linkWdata(linkWdata), .linkAck(linkAck), .linkRdata(linkRdata),
    .linkDir(linkDir), .linkDirPulse(linkDirPulse)
  );

  function automatic logic [7:0] rdFor(input int n);
    return 8'((n * 37 + 11) & 255);
  endfunction

  function automatic logic [31:0] maskOf(input logic [1:0] sz);
    return (sz == 2'd1) ? 32'h0000FFFF : (sz == 2'd2) ? 32'hFFFFFFFF : 32'h000000FF;
  endfunction

  function automatic int bytesOf(input logic isAddr, input logic [1:0] sz);
    if (isAddr) return 1;
    return (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 1;
  endfunction

  function automatic logic gateOk(input logic [7:0] c, input logic wr);
    return wr ? ((c & 8'h2F) == 8'h04) : ((c & 8'h2F) == 8'h24);
  endfunction

  // link responder, driven away from the active edge
  always @(negedge clk) begin
    if (linkDirPulse) pulses++;
    if (!linkReq || linkAck) begin
      linkAck = 1'b0;
      waitCnt = 0;
    end else if (waitCnt == ackDelay) begin
      linkAck   = 1'b1;
      linkRdata = rdFor(logCount);
      logData[logCount] = linkWrite ? linkWdata : linkRdata;
      logAddr[logCount] = linkIsAddr;
      logWr[logCount]   = linkWrite;
      logCount++;
    end else begin
      waitCnt++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [10:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, output logic [31:0] rd);
    @(negedge clk);
    busReq = 1'b1; busWrite = wr; busAddr = a; busSize = sz; busWdata = wd;
    do @(negedge clk); while (!busReady);
    rd = busRdata;
    busReq = 1'b0;
    @(negedge clk);
    chk("R10 ready single cycle", {31'b0, busReady}, 32'h0);
  endtask

  task automatic finish;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got hung expected done");
    finish();
  end

  initial begin
    logic [31:0] rd, exp;
    logic [7:0]  ctlModel;
    int base, p0;
    void'($urandom(32'h5EED_1234));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ready low", {31'b0, busReady}, 0);
    chk("R1 linkReq low", {31'b0, linkReq}, 0);
    access(0, 11'h002, 0, 0, rd); chk("R1 control reset", rd, 32'hCC);
    access(0, 11'h001, 0, 0, rd); chk("R1 status reset", rd, 32'hAA);
    ctlModel = 8'hCC;

    // R3 gated-off write at reset pattern
    base = logCount;
    access(1, 11'h004, 2, 32'hDEADBEEF, rd);
    chk("R3 gated write no link", logCount - base, 0);

    // R8 control write, no direction change
    p0 = pulses;
    access(1, 11'h002, 0, 32'h04, rd); ctlModel = 8'hC4;
    access(0, 11'h002, 0, 0, rd); chk("R8 forced bits", rd, 32'hC4);
    chk("R8 no pulse", pulses - p0, 0);

    // R2 address port, upper offset bits ignored
    base = logCount;
    access(1, 11'h00B, 0, 32'h5A, rd);
    chk("R2 addr cycle count", logCount - base, 1);
    chk("R2 addr flag", {31'b0, logAddr[base]}, 1);
    chk("R2 addr byte", {24'b0, logData[base]}, 32'h5A);

    // R5 little-endian 32-bit write
    base = logCount;
    access(1, 11'h004, 2, 32'h11223344, rd);
    chk("R5 four bytes", logCount - base, 4);
    chk("R5 byte order", {logData[base+3], logData[base+2], logData[base+1], logData[base]}, 32'h11223344);
    chk("R2 data flag", {31'b0, logAddr[base]}, 0);

    // R4 read while write pattern set
    base = logCount;
    access(0, 11'h004, 1, 0, rd);
    chk("R4 gated read ones", rd, 32'h0000FFFF);
    chk("R4 gated read no link", logCount - base, 0);

    // R8 direction change to read pattern
    p0 = pulses;
    access(1, 11'h002, 0, 32'h24, rd); ctlModel = 8'hE4;
    chk("R8 one pulse", pulses - p0, 1);
    chk("R8 linkDir", {31'b0, linkDir}, 1);

    // R5 32-bit read assembly
    base = logCount;
    access(0, 11'h004, 2, 0, rd);
    chk("R5 read assembly", rd, {rdFor(base+3), rdFor(base+2), rdFor(base+1), rdFor(base)});
    chk("R5 read direction", {31'b0, logWr[base]}, 0);
    // R2 wide read on address port: one byte, rest ones
    base = logCount;
    access(0, 11'h003, 1, 0, rd);
    chk("R2 addr port wide read", rd, {16'h0, 8'hFF, rdFor(base)});

    // R6 acknowledge on last allowed cycle vs expiry
    ackDelay = TMO - 1;
    base = logCount;
    access(0, 11'h004, 0, 0, rd);
    chk("R6 last-cycle ack ok", rd, {24'h0, rdFor(base)});
    access(0, 11'h001, 0, 0, rd); chk("R6 flag still clear", rd, 32'hAA);
    ackDelay = TMO;
    base = logCount;
    access(0, 11'h004, 2, 0, rd);
    chk("R6 timeout read ones", rd, 32'hFFFFFFFF);
    chk("R6 timeout no byte", logCount - base, 0);
    access(0, 11'h001, 0, 0, rd); chk("R6 flag set", rd, 32'hAB);

    // R7 clear behaviour
    access(1, 11'h001, 0, 32'hFE, rd);
    access(0, 11'h001, 0, 0, rd); chk("R7 bit0=0 keeps flag", rd, 32'hAB);
    access(1, 11'h001, 0, 32'h01, rd);
    access(0, 11'h001, 0, 0, rd); chk("R7 bit0=1 clears", rd, 32'hAA);
    ackDelay = 0;

    // R9 empty region
    access(0, 11'h404, 2, 0, rd); chk("R9 ext read ones", rd, 32'hFFFFFFFF);
    access(0, 11'h402, 0, 0, rd); chk("R9 ext ctl read", rd, 32'hFF);
    base = logCount;
    access(1, 11'h402, 0, 32'h00, rd);
    access(1, 11'h404, 0, 32'h00, rd);
    access(0, 11'h002, 0, 0, rd); chk("R9 ext write no effect", rd, {24'h0, ctlModel});
    chk("R9 ext no link", logCount - base, 0);

    // random mix
    for (int it = 0; it < 80; it++) begin
      logic [7:0] cv;
      logic wr, isA;
      logic [1:0] sz;
      logic [31:0] wd;
      int n, sel;
      sel = $urandom_range(0, 5);
      cv = (sel == 0) ? 8'h04 : (sel == 1) ? 8'h24 : (sel == 2) ? 8'h2C :
           (sel == 3) ? 8'h05 : (sel == 4) ? 8'h14 : 8'($urandom);
      p0 = pulses;
      access(1, 11'h002, 0, {24'h0, cv}, rd);
      chk("R8 random pulse", pulses - p0, (cv[5] != ctlModel[5]) ? 1 : 0);
      ctlModel = cv | 8'hC0;
      wr = 1'($urandom);
      isA = ($urandom_range(0, 3) == 0);
      sz = 2'($urandom_range(0, 3));
      wd = $urandom;
      ackDelay = $urandom_range(0, 3);
      base = logCount;
      access(wr, isA ? 11'h003 : 11'h004, sz, wd, rd);
      n = gateOk(ctlModel, wr) ? bytesOf(isA, sz) : 0;
      chk(wr ? "R3 random byte count" : "R4 random byte count", logCount - base, n);
      if (wr && n > 0) begin
        for (int k = 0; k < n; k++)
          chk("R5 random write byte", {24'h0, logData[base+k]}, {24'h0, wd[k*8 +: 8]});
      end
      if (!wr) begin
        exp = 32'hFFFFFFFF;
        for (int k = 0; k < n; k++) exp[k*8 +: 8] = rdFor(base + k);
        chk("R4 random read value", rd, exp & maskOf(sz));
      end
    end

    finish();
  end

endmodule